// File: doc/BRIEF.md
# Low-Power Watch Mode Controller

This block is the power-mode sequencer of a small microcontroller. It tracks which of three running clock modes the core is in (high-speed, medium-speed or subactive). It decides whether a sleep request from the CPU turns into watch mode. In watch mode, the CPU clock and every peripheral clock are switched off. Only the clock of the second watchdog timer keeps running. A sleep request is acted on only when three control bits agree. Otherwise it is ignored, and the clocks are never left partly gated.

The block leaves watch mode on a qualified interrupt. The low-speed-on bit picks the destination. When that bit is clear, a medium-select bit chooses between medium-speed and high-speed. A return to high-speed first waits a stabilization count chosen by a 3-bit field, while the CPU clock stays off. Arrival in a running mode after a wake is marked by a one-cycle exception-start pulse. The hardware standby pin and the reset pin override everything else. All clock-gate outputs come straight from flops.

Top module: `pwr_watch_ctrl`

## Requirements
- R1: A sleep request while in high-speed (`mode_o`=00) or subactive (`mode_o`=10) enters watch (`mode_o`=11) at that clock edge when `sby_sel`=1, `direct_xfer`=0 and `wdt_src_sel`=1.
- R2: A sleep request is ignored when any of those three bits disagrees, or when the mode is medium-speed (`mode_o`=01). Mode and clock enables are then unchanged.
- R3: While `mode_o`=11, `cpu_clk_en` and every bit of `periph_clk_en` are 0 and `wdt_clk_en` is 1. At all times, every bit of `periph_clk_en` equals `cpu_clk_en`.
- R4: Watch mode is left on any of the following: `nmi`; an `irq` bit among 0, 1, 2, 6 and 7 whose `irq_en` bit is 1; or `wdt_ovf` with `wdt_ovf_en`=1 and `cpu_mask`=0. Nothing else exits it, including IRQ bits 3 to 5, disabled IRQs and masked or disabled overflows.
- R5: A wake with `low_spd_on`=1 enters subactive (10). A wake with `low_spd_on`=0 and `med_sel`=1 enters medium-speed (01). In both cases clocks turn on and `exc_start` pulses at the wake edge.
- R6: A wake with `low_spd_on`=0 and `med_sel`=0 keeps `mode_o`=11 with the CPU clock off, for W = 2^(`stab_sel`+STS_BASE) cycles. At the W-th edge after the wake edge, the block enters high-speed (00), turns the clocks on and pulses `exc_start`.
- R7: At every edge with `hw_stby`=1, the block goes to high-speed state with all clock enables 0 (including `wdt_clk_en`), `mode_o`=00 and no `exc_start`. This overrides any wake in the same cycle.
- R8: `exc_start` is never high for two cycles in a row, and it is high only while `cpu_clk_en` is 1.
- R9: After reset, `mode_o`=00, all clock enables are 1 and `exc_start`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset pin, active low |
| hw_stby | input | 1 | Hardware standby pin, active high |
| sleep_req | input | 1 | Sleep strobe from the CPU |
| sby_sel | input | 1 | Standby-select control bit |
| direct_xfer | input | 1 | Direct-transition control bit |
| wdt_src_sel | input | 1 | Watchdog clock-source select bit |
| low_spd_on | input | 1 | Wake destination: 1 = subactive |
| med_sel | input | 1 | With low_spd_on=0: 1 = medium, 0 = high |
| stab_sel | input | 3 | Oscillator stabilization count select |
| nmi | input | 1 | Non-maskable interrupt |
| irq | input | 8 | External interrupt requests |
| irq_en | input | 8 | Per-IRQ enables |
| wdt_ovf | input | 1 | Watchdog overflow interrupt |
| wdt_ovf_en | input | 1 | Overflow interrupt enable |
| cpu_mask | input | 1 | CPU mask for peripheral interrupts |
| mode_o | output | 2 | 00 high, 01 medium, 10 subactive, 11 watch |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | N_PERIPH | Peripheral clock enables |
| wdt_clk_en | output | 1 | Second watchdog clock enable |
| exc_start | output | 1 | One-cycle exception-start pulse |

## Verification
The hardest state to reach is a wake from watch mode into high-speed while the stabilization count is still running. A correct test must also check that interrupts arriving during that wait do nothing and that a standby pulse cuts it short. The random stimulus keeps the three entry bits near their entry values, so that watch mode is entered often. It drives sparse mixed interrupts and small stabilization selects, so the stabilization state is visited many times. Directed sequences cover the longest count, the IRQ lines that must never wake, and a standby that collides with a wake.

// File: rtl/pwr_watch_pkg.sv
package pwr_watch_pkg;
  typedef enum logic [1:0] {
    MODE_HIGH  = 2'b00,
    MODE_MED   = 2'b01,
    MODE_SUB   = 2'b10,
    MODE_WATCH = 2'b11
  } pw_mode_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'b00,
    ST_WATCH = 2'b01,
    ST_STAB  = 2'b10
  } pw_state_e;

  // stabilization length in cycles for a given select value
  function automatic int unsigned stab_wait(input logic [2:0] sel, input int unsigned base);
    return 32'd1 << (int'(sel) + base);
  endfunction
endpackage

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual #(
  parameter logic [7:0] WAKE_IRQ_MASK = 8'hC7
) (
  input  logic       nmi,
  input  logic [7:0] irq,
  input  logic [7:0] irq_en,
  input  logic       wdt_ovf,
  input  logic       wdt_ovf_en,
  input  logic       cpu_mask,
  output logic       wake
);
  logic irq_hit;
  logic ovf_hit;

  assign irq_hit = |(irq & irq_en & WAKE_IRQ_MASK);
  assign ovf_hit = wdt_ovf & wdt_ovf_en & ~cpu_mask;
  assign wake    = nmi | irq_hit | ovf_hit;
endmodule

// File: rtl/pwr_stab_timer.sv
module pwr_stab_timer #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;
  logic          busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (clear) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (load) begin
      cnt  <= load_val;
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign expired = busy && (cnt == '0);
endmodule

// File: rtl/pwr_watch_ctrl.sv
module pwr_watch_ctrl
  import pwr_watch_pkg::*;
#(
  parameter int         N_PERIPH      = 4,
  parameter int         STS_BASE      = 8,
  parameter logic [7:0] WAKE_IRQ_MASK = 8'hC7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hw_stby,
  input  logic                sleep_req,
  input  logic                sby_sel,
  input  logic                direct_xfer,
  input  logic                wdt_src_sel,
  input  logic                low_spd_on,
  input  logic                med_sel,
  input  logic [2:0]          stab_sel,
  input  logic                nmi,
  input  logic [7:0]          irq,
  input  logic [7:0]          irq_en,
  input  logic                wdt_ovf,
  input  logic                wdt_ovf_en,
  input  logic                cpu_mask,
  output logic [1:0]          mode_o,
  output logic                cpu_clk_en,
  output logic [N_PERIPH-1:0] periph_clk_en,
  output logic                wdt_clk_en,
  output logic                exc_start
);
  localparam int CW = STS_BASE + 7;

  pw_state_e st, nx_st;
  pw_mode_e  run_mode, nx_run;
  logic      enter_ok;
  logic      wake_hit;
  logic      stab_expired;
  logic      stab_load;
  logic      exc_nx;
  logic      run_nx;
  logic [CW-1:0] stab_val;

  pwr_wake_qual #(.WAKE_IRQ_MASK(WAKE_IRQ_MASK)) u_qual (
    .nmi(nmi), .irq(irq), .irq_en(irq_en), .wdt_ovf(wdt_ovf),
    .wdt_ovf_en(wdt_ovf_en), .cpu_mask(cpu_mask), .wake(wake_hit)
  );

  assign stab_val = CW'(stab_wait(stab_sel, STS_BASE) - 1);

  pwr_stab_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(hw_stby), .load(stab_load),
    .load_val(stab_val), .expired(stab_expired)
  );

  assign enter_ok = sleep_req && sby_sel && !direct_xfer && wdt_src_sel &&
                    (st == ST_RUN) && (run_mode == MODE_HIGH || run_mode == MODE_SUB);

  always_comb begin
    nx_st     = st;
    nx_run    = run_mode;
    stab_load = 1'b0;
    exc_nx    = 1'b0;
    if (hw_stby) begin
      nx_st  = ST_RUN;
      nx_run = MODE_HIGH;
    end else begin
      unique case (st)
        ST_RUN:   if (enter_ok) nx_st = ST_WATCH;
        ST_WATCH: if (wake_hit) begin
          if (low_spd_on) begin
            nx_st = ST_RUN; nx_run = MODE_SUB; exc_nx = 1'b1;
          end else if (med_sel) begin
            nx_st = ST_RUN; nx_run = MODE_MED; exc_nx = 1'b1;
          end else begin
            nx_st = ST_STAB; stab_load = 1'b1;
          end
        end
        ST_STAB:  if (stab_expired) begin
          nx_st = ST_RUN; nx_run = MODE_HIGH; exc_nx = 1'b1;
        end
        default:  nx_st = ST_RUN;
      endcase
    end
  end

  assign run_nx = (nx_st == ST_RUN) && !hw_stby;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= ST_RUN;
      run_mode      <= MODE_HIGH;
      mode_o        <= MODE_HIGH;
      cpu_clk_en    <= 1'b1;
      periph_clk_en <= '1;
      wdt_clk_en    <= 1'b1;
      exc_start     <= 1'b0;
    end else begin
      st            <= nx_st;
      run_mode      <= nx_run;
      mode_o        <= (nx_st == ST_RUN) ? nx_run : MODE_WATCH;
      cpu_clk_en    <= run_nx;
      periph_clk_en <= {N_PERIPH{run_nx}};
      wdt_clk_en    <= !hw_stby;
      exc_start     <= exc_nx;
    end
  end
endmodule

// File: rtl/pwr_watch_chk.sv
module pwr_watch_chk #(
  parameter int N_PERIPH = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                hw_stby,
  input logic                sleep_req,
  input logic                sby_sel,
  input logic                direct_xfer,
  input logic                wdt_src_sel,
  input logic [1:0]          mode_o,
  input logic                cpu_clk_en,
  input logic [N_PERIPH-1:0] periph_clk_en,
  input logic                wdt_clk_en,
  input logic                exc_start,
  input logic                enter_ok,
  input logic                wake_hit,
  input logic                stab_expired
);
  p_enter_watch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_ok && !hw_stby) |=> (mode_o == 2'b11));

  p_ignore_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && !(sby_sel && !direct_xfer && wdt_src_sel) && mode_o != 2'b11 && !hw_stby)
      |=> $stable(mode_o));

  p_watch_gates_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b11) |-> (!cpu_clk_en && periph_clk_en == '0 && wdt_clk_en));

  p_no_partial_r3: assert property (@(posedge clk) disable iff (!rst_n)
    periph_clk_en == {N_PERIPH{cpu_clk_en}});

  p_stay_asleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b11 && !wake_hit && !stab_expired && !hw_stby) |=> (mode_o == 2'b11));

  p_stby_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> (!cpu_clk_en && !wdt_clk_en && mode_o == 2'b00 && !exc_start));

  p_exc_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_start |=> !exc_start);

  p_exc_clock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_start |-> cpu_clk_en);
endmodule

bind pwr_watch_ctrl pwr_watch_chk #(.N_PERIPH(N_PERIPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sleep_req(sleep_req),
  .sby_sel(sby_sel), .direct_xfer(direct_xfer), .wdt_src_sel(wdt_src_sel),
  .mode_o(mode_o), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
  .wdt_clk_en(wdt_clk_en), .exc_start(exc_start), .enter_ok(enter_ok),
  .wake_hit(wake_hit), .stab_expired(stab_expired)
);

// File: tb/pwr_watch_ctrl_test.sv
module pwr_watch_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int BASE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_stby = 0, sleep_req = 0, sby_sel = 0, direct_xfer = 0, wdt_src_sel = 0;
  logic low_spd_on = 0, med_sel = 0, nmi = 0, wdt_ovf = 0, wdt_ovf_en = 0, cpu_mask = 0;
  logic [2:0] stab_sel = 0;
  logic [7:0] irq = 0, irq_en = 0;
  logic [1:0] mode_o;
  logic cpu_clk_en, wdt_clk_en, exc_start;
  logic [NP-1:0] periph_clk_en;

  int tests = 0, fails = 0;
  bit done = 0;

  // bench model state: 0 run, 1 watch, 2 stabilizing
  int ms = 0;
  logic [1:0] em = 2'b00;
  int cnt = 0;
  logic e_exc = 0, e_wdt = 1;
  string tag = "R9";

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_watch_ctrl #(.N_PERIPH(NP), .STS_BASE(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sleep_req(sleep_req),
    .sby_sel(sby_sel), .direct_xfer(direct_xfer), .wdt_src_sel(wdt_src_sel),
    .low_spd_on(low_spd_on), .med_sel(med_sel), .stab_sel(stab_sel), .nmi(nmi),
    .irq(irq), .irq_en(irq_en), .wdt_ovf(wdt_ovf), .wdt_ovf_en(wdt_ovf_en),
    .cpu_mask(cpu_mask), .mode_o(mode_o), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .wdt_clk_en(wdt_clk_en), .exc_start(exc_start)
  );

  function automatic int wait_len(input logic [2:0] s);
    int n = 1;
    for (int i = 0; i < int'(s) + BASE; i++) n = n * 2;
    return n;
  endfunction

  function automatic bit wakes();
    bit w = nmi;
    for (int i = 0; i < 8; i++)
      if ((i < 3 || i > 5) && irq[i] && irq_en[i]) w = 1;
    if (wdt_ovf && wdt_ovf_en && !cpu_mask) w = 1;
    return w;
  endfunction

  task automatic model_edge();
    e_exc = 0;
    e_wdt = 1;
    if (hw_stby) begin
      ms = 0; em = 2'b00; cnt = 0; e_wdt = 0; tag = "R7";
    end else if (ms == 0) begin
      if (sleep_req && (em == 2'b00 || em == 2'b10)) begin
        if (sby_sel && !direct_xfer && wdt_src_sel) begin ms = 1; tag = "R1"; end
        else tag = "R2";
      end else if (sleep_req) tag = "R2";
      else tag = "R5";
    end else if (ms == 1) begin
      tag = "R4";
      if (wakes()) begin
        if (low_spd_on) begin ms = 0; em = 2'b10; e_exc = 1; tag = "R5"; end
        else if (med_sel) begin ms = 0; em = 2'b01; e_exc = 1; tag = "R5"; end
        else begin ms = 2; cnt = wait_len(stab_sel) - 1; tag = "R6"; end
      end
    end else begin
      tag = "R6";
      if (cnt == 0) begin ms = 0; em = 2'b00; e_exc = 1; end
      else cnt = cnt - 1;
    end
  endtask

  task automatic check_outputs();
    logic cpu_e;
    logic [6:0] act, exp;
    cpu_e = (ms == 0) && e_wdt;
    act = {mode_o, cpu_clk_en, &periph_clk_en, |periph_clk_en, wdt_clk_en, exc_start};
    exp = {(ms != 0) ? 2'b11 : em, cpu_e, cpu_e, cpu_e, e_wdt, e_exc};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {mode,cpu,per_and,per_or,wdt,exc} got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    check_outputs();
  endtask

  task automatic quiet();
    hw_stby = 0; sleep_req = 0; nmi = 0; irq = 0; wdt_ovf = 0;
  endtask

  task automatic enter_watch();
    quiet();
    sleep_req = 1; sby_sel = 1; direct_xfer = 0; wdt_src_sel = 1;
    step();
    sleep_req = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    // R9: reset values
    tag = "R9";
    check_outputs();

    // R2: wrong control bits ignore sleep
    quiet(); sleep_req = 1; sby_sel = 1; direct_xfer = 1; wdt_src_sel = 1; step();
    sleep_req = 1; sby_sel = 1; direct_xfer = 0; wdt_src_sel = 0; step();

    // R1 then R4: IRQ3..5, disabled IRQ and masked overflow do not wake
    enter_watch();
    irq = 8'h38; irq_en = 8'hFF; step();
    irq = 8'h01; irq_en = 8'hFE; step();
    irq = 0; wdt_ovf = 1; wdt_ovf_en = 1; cpu_mask = 1; step();
    wdt_ovf_en = 0; cpu_mask = 0; step();
    // R5: wake through IRQ6 into medium-speed
    quiet(); irq = 8'h40; irq_en = 8'h40; low_spd_on = 0; med_sel = 1; step();
    quiet(); step();
    // R2: sleep in medium mode is ignored
    sleep_req = 1; step(); quiet();
    hw_stby = 1; step(); quiet(); step();

    // R6: longest stabilization wait, interrupts during wait ignored
    enter_watch();
    stab_sel = 3'd7; low_spd_on = 0; med_sel = 0; nmi = 1; step();
    quiet(); irq = 8'hFF; irq_en = 8'hFF;
    for (int i = 0; i < wait_len(3'd7) + 3; i++) step();
    quiet();

    // R7: standby colliding with a wake wins
    enter_watch();
    nmi = 1; hw_stby = 1; low_spd_on = 1; step();
    quiet(); step();

    // R7: standby during stabilization
    enter_watch();
    stab_sel = 3'd2; low_spd_on = 0; med_sel = 0; nmi = 1; step();
    quiet(); step(); hw_stby = 1; step(); quiet(); step();

    // random phase
    for (int n = 0; n < 6000; n++) begin
      sleep_req   = ($urandom % 4) == 0;
      sby_sel     = ($urandom % 8) != 0;
      direct_xfer = ($urandom % 8) == 0;
      wdt_src_sel = ($urandom % 8) != 0;
      low_spd_on  = ($urandom % 3) == 0;
      med_sel     = ($urandom % 3) == 0;
      stab_sel    = 3'($urandom % 3);
      nmi         = ($urandom % 40) == 0;
      irq         = (($urandom % 6) == 0) ? 8'($urandom) : 8'h00;
      irq_en      = 8'($urandom);
      wdt_ovf     = ($urandom % 10) == 0;
      wdt_ovf_en  = 1'($urandom);
      cpu_mask    = 1'($urandom);
      hw_stby     = ($urandom % 64) == 0;
      step();
    end
    finish_run();
  end
endmodule